// File: doc/BRIEF.md
# I2C Serial Clock Timing Generator

This block derives the serial clock of an I2C controller from a fast functional clock. A prescaler divides the functional clock into an internal timing tick. The clock then alternates between a driven-low phase and a released-high phase, and each phase lasts a programmed number of ticks plus a fixed offset. The low-phase and high-phase settings each pack two byte-wide counts. The lower byte is used while the bus runs at standard or fast rate, or in the arbitration part of a high-speed transfer. The upper byte is used during the high-speed data part. A select input picks between them.

The generator drives the clock line open-drain style: `scl_o` low means pull the line down, and high means release it. The block watches the line as sensed on the bus. While the line is released but another device still holds it low, the high phase does not advance, which gives clock stretching. One-cycle strobes mark the first cycle of every low phase and every high phase, so a byte engine can change data and sample it on those boundaries. Settings that would give a zero divider or a zero count are flagged, and the clock stays released while they are present. Working out the setting values for a target bus rate is left to software.

Top module: `scl_timing_gen`

## Requirements
- R1: Under reset and afterwards while disabled, `scl_o` is 1 (released) and both strobes are 0.
- R2: The internal tick occurs once every `psc_div`+1 functional clock cycles, so every phase length in clock cycles is a whole multiple of `psc_div`+1.
- R3: Without stretching, a low phase lasts (selected low count + 7) ticks.
- R4: Without stretching, a high phase lasts (selected high count + 5) ticks.
- R5: With `hs_sel`=0 the counts come from bits 7:0 of `low_cfg` and `high_cfg`. With `hs_sel`=1 they come from bits 15:8.
- R6: A phase takes its count when it begins. A change of `hs_sel` during a phase affects the next phase, not the current one.
- R7: During a high phase, every clock cycle in which `scl_in` is sampled 0 adds one cycle to that phase.
- R8: When `enable` goes low, `scl_o` is 1 from the next cycle and all counters clear. After enable returns, the first low phase has its full length.
- R9: `cfg_bad` is 1 when `psc_div` is 0 or either selected count is 0. While it is 1, `scl_o` is held at 1.
- R10: `low_start` is 1 exactly in the first cycle of each low phase, and `high_start` exactly in the first cycle of each high phase. The two are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Runs the generator when 1 |
| hs_sel | input | 1 | 0: lower count bytes, 1: upper count bytes |
| psc_div | input | 8 | Prescaler; tick period is psc_div+1 clocks |
| low_cfg | input | 16 | Low-phase counts {high-speed byte, first-phase byte} |
| high_cfg | input | 16 | High-phase counts {high-speed byte, first-phase byte} |
| scl_in | input | 1 | Clock line as sensed on the bus, synchronised |
| scl_o | output | 1 | 0 = pull clock line low, 1 = release |
| low_start | output | 1 | Strobe in the first cycle of a low phase |
| high_start | output | 1 | Strobe in the first cycle of a high phase |
| cfg_bad | output | 1 | Current divider or selected count is zero |

## Verification
The bench runs the clock under two prescaler values with unequal low and high counts. This separates the tick scaling from the two offsets, and catches a low and high offset swapped between phases. It selects the upper count bytes, and in one run it flips the select partway through a low phase, so that reading the select per tick rather than per phase shows up as a wrong length. A bus model holds the line low at the start of each high phase to check that the phase grows by exactly the held cycles. Other runs disable the block in the middle of a low phase and re-enable it, apply a zero divider and a zero upper byte, and check that the strobes line up with every clock edge.

// File: rtl/scl_timing_pkg.sv
// Shared types for the serial clock timing generator.
package scl_timing_pkg;

    // Phase of the generated clock.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_t;

endpackage

// File: rtl/scl_prescaler.sv
// Divides the functional clock into the internal timing tick.
// A tick is one cycle wide and comes every psc+1 cycles while active.
// Assumes: while stall is 1 the count freezes and no tick is issued, so a
// stretched phase resumes exactly where it stopped.
module scl_prescaler #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             stall,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PSC_W-1:0] div_cnt;
    logic             wrap;

    assign wrap = (div_cnt == psc);
    assign tick = active && !stall && wrap;

    // Divider count: cleared while inactive, frozen while stalled.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            div_cnt <= '0;
        end else if (!stall) begin
            if (wrap) div_cnt <= '0;
            else      div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/scl_len_sel.sv
// Chooses the low and high count bytes for the current bus phase and adds
// the fixed offsets. Also flags settings that cannot be run.
// Assumes: configuration inputs are static or change only between phases
// as far as the caller cares; the phase machine latches the lengths.
module scl_len_sel #(
    parameter int PSC_W    = 8,
    parameter int BYTE_W   = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5,
    parameter int LEN_W    = 9
) (
    input  logic [PSC_W-1:0]    psc,
    input  logic [2*BYTE_W-1:0] low_cfg,
    input  logic [2*BYTE_W-1:0] high_cfg,
    input  logic                hs_sel,
    output logic [LEN_W-1:0]    low_len,
    output logic [LEN_W-1:0]    high_len,
    output logic                bad
);

    logic [BYTE_W-1:0] low_byte;
    logic [BYTE_W-1:0] high_byte;

    // Byte selection by bus phase: upper byte for the high-speed part.
    always_comb begin
        if (hs_sel) begin
            low_byte  = low_cfg[2*BYTE_W-1:BYTE_W];
            high_byte = high_cfg[2*BYTE_W-1:BYTE_W];
        end else begin
            low_byte  = low_cfg[BYTE_W-1:0];
            high_byte = high_cfg[BYTE_W-1:0];
        end
    end

    // Phase lengths in ticks, offset added.
    always_comb begin
        low_len  = LEN_W'(low_byte)  + LEN_W'(LOW_OFS);
        high_len = LEN_W'(high_byte) + LEN_W'(HIGH_OFS);
    end

    // Unusable setting: zero divider or zero selected count.
    always_comb begin
        bad = (psc == '0) || (low_byte == '0) || (high_byte == '0);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
// Alternates the clock between driven-low and released-high phases, each
// lasting a latched number of ticks. Holds the high phase while the sensed
// line is still low (clock stretching). Issues a strobe on each phase start.
// Assumes: scl_in is already synchronised to clk; the length inputs are
// sampled only when a phase begins.
module scl_phase_fsm #(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    input  logic             scl_in,
    output logic             active,
    output logic             stall,
    output logic             in_high,
    output logic             scl_o,
    output logic             low_start,
    output logic             high_start
);
    import scl_timing_pkg::*;

    phase_t           phase;
    logic [LEN_W-1:0] tick_cnt;
    logic [LEN_W-1:0] len_q;
    logic             last_tick;

    assign active    = (phase != PH_IDLE);
    assign in_high   = (phase == PH_HIGH);
    assign stall     = in_high && !scl_in;
    assign scl_o     = (phase != PH_LOW);
    assign last_tick = tick && (tick_cnt == len_q - LEN_W'(1));

    // Phase sequencing, tick counting and phase-start strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            tick_cnt   <= '0;
            len_q      <= '0;
            low_start  <= 1'b0;
            high_start <= 1'b0;
        end else begin
            low_start  <= 1'b0;
            high_start <= 1'b0;
            if (!run) begin
                phase    <= PH_IDLE;
                tick_cnt <= '0;
            end else begin
                case (phase)
                    PH_IDLE: begin
                        phase     <= PH_LOW;
                        len_q     <= low_len;
                        tick_cnt  <= '0;
                        low_start <= 1'b1;
                    end
                    PH_LOW: begin
                        if (last_tick) begin
                            phase      <= PH_HIGH;
                            len_q      <= high_len;
                            tick_cnt   <= '0;
                            high_start <= 1'b1;
                        end else if (tick) begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    PH_HIGH: begin
                        if (last_tick) begin
                            phase     <= PH_LOW;
                            len_q     <= low_len;
                            tick_cnt  <= '0;
                            low_start <= 1'b1;
                        end else if (tick) begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                    default: begin
                        phase    <= PH_IDLE;
                        tick_cnt <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/scl_timing_gen.sv
// Serial clock timing generator for an I2C controller: prescaler, byte
// selection with fixed offsets, and the low/high phase machine with
// stretch detection.
// Assumes: scl_in is synchronised to clk; configuration is changed while
// disabled, except hs_sel which may change at any time.
module scl_timing_gen #(
    parameter int PSC_W    = 8,
    parameter int BYTE_W   = 8,
    parameter int LOW_OFS  = 7,
    parameter int HIGH_OFS = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                hs_sel,
    input  logic [PSC_W-1:0]    psc_div,
    input  logic [2*BYTE_W-1:0] low_cfg,
    input  logic [2*BYTE_W-1:0] high_cfg,
    input  logic                scl_in,
    output logic                scl_o,
    output logic                low_start,
    output logic                high_start,
    output logic                cfg_bad
);

    localparam int MAX_OFS = (LOW_OFS > HIGH_OFS) ? LOW_OFS : HIGH_OFS;
    localparam int MAX_LEN = (1 << BYTE_W) - 1 + MAX_OFS;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);

    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic             run;
    logic             tick;
    logic             fsm_active;
    logic             fsm_stall;
    logic             fsm_in_high;

    assign run = enable && !cfg_bad;

    scl_len_sel #(
        .PSC_W   (PSC_W),
        .BYTE_W  (BYTE_W),
        .LOW_OFS (LOW_OFS),
        .HIGH_OFS(HIGH_OFS),
        .LEN_W   (LEN_W)
    ) u_len (
        .psc     (psc_div),
        .low_cfg (low_cfg),
        .high_cfg(high_cfg),
        .hs_sel  (hs_sel),
        .low_len (low_len),
        .high_len(high_len),
        .bad     (cfg_bad)
    );

    scl_prescaler #(
        .PSC_W(PSC_W)
    ) u_psc (
        .clk   (clk),
        .rst_n (rst_n),
        .active(fsm_active),
        .stall (fsm_stall),
        .psc   (psc_div),
        .tick  (tick)
    );

    scl_phase_fsm #(
        .LEN_W(LEN_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .tick      (tick),
        .low_len   (low_len),
        .high_len  (high_len),
        .scl_in    (scl_in),
        .active    (fsm_active),
        .stall     (fsm_stall),
        .in_high   (fsm_in_high),
        .scl_o     (scl_o),
        .low_start (low_start),
        .high_start(high_start)
    );

endmodule

// File: rtl/scl_timing_chk.sv
// Property checker for the serial clock timing generator, bound to the top.
module scl_timing_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic cfg_bad,
    input logic scl_in,
    input logic scl_o,
    input logic low_start,
    input logic high_start,
    input logic in_high
);

    AST_DISABLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> scl_o);                                          // R8
    AST_BAD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_bad |=> scl_o);                                          // R9
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !cfg_bad && in_high && !scl_in) |=> scl_o);       // R7
    AST_LOW_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        low_start |-> !scl_o);                                       // R10
    AST_HIGH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        high_start |-> scl_o);                                       // R10
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(low_start && high_start));                                 // R10

endmodule

bind scl_timing_gen scl_timing_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .cfg_bad   (cfg_bad),
    .scl_in    (scl_in),
    .scl_o     (scl_o),
    .low_start (low_start),
    .high_start(high_start),
    .in_high   (fsm_in_high)
);

// File: tb/tb_scl_timing_gen.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected phase lengths, the monitor
// measures each clock phase at the ports and compares.
module tb_scl_timing_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        hs_sel = 1'b0;
    logic [7:0]  psc_div = 8'd1;
    logic [15:0] low_cfg = 16'h0101;
    logic [15:0] high_cfg = 16'h0101;
    logic        hold = 1'b0;
    logic        scl_in;
    logic        scl_o;
    logic        low_start;
    logic        high_start;
    logic        cfg_bad;

    int n_checks = 0;
    int n_fail = 0;
    int exp_len[$];
    string exp_tag[$];
    int stretch_req = 0;
    int hold_left = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit have_edge = 0;
    logic prev_scl = 1'b1;
    bit done = 0;

    // wired-AND bus: released line is low while the bus model holds it
    assign scl_in = scl_o & ~hold;

    always #2 clk = ~clk;

    scl_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .hs_sel(hs_sel),
        .psc_div(psc_div), .low_cfg(low_cfg), .high_cfg(high_cfg),
        .scl_in(scl_in), .scl_o(scl_o), .low_start(low_start),
        .high_start(high_start), .cfg_bad(cfg_bad)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Push one low/high pair of expected lengths in clock cycles.
    task automatic push_pair(input int psc, input int lb, input int hb, input int str);
        exp_len.push_back((lb + 7) * (psc + 1)); exp_tag.push_back("R3 low length");
        exp_len.push_back((hb + 5) * (psc + 1) + str); exp_tag.push_back("R4/R7 high length");
    endtask

    task automatic wait_drain();
        for (int g = 0; g < 20000 && exp_len.size() > 0; g++) @(negedge clk);
        if (exp_len.size() > 0) begin
            check(0, "R2 phases missing", exp_len.size(), 0);
            exp_len.delete(); exp_tag.delete();
        end
    endtask

    task automatic run_case(input int psc, input logic [15:0] lc, input logic [15:0] hc,
                            input logic hs, input int pairs, input int str);
        int lb, hb;
        lb = hs ? int'(lc[15:8]) : int'(lc[7:0]);
        hb = hs ? int'(hc[15:8]) : int'(hc[7:0]);
        psc_div = 8'(psc); low_cfg = lc; high_cfg = hc; hs_sel = hs;
        stretch_req = str;
        for (int p = 0; p < pairs; p++) push_pair(psc, lb, hb, str);
        enable = 1'b1;
        wait_drain();
        enable = 1'b0;
        stretch_req = 0;
        repeat (3) @(negedge clk);
    endtask

    // Monitor: measure phases between clock edges, check strobes, model stretch.
    always @(negedge clk) begin
        cyc++;
        if (hold_left > 0) begin
            hold_left--;
            if (hold_left == 0) hold = 1'b0;
        end
        if (rst_n && scl_o !== prev_scl) begin
            if (have_edge && exp_len.size() > 0) begin
                int e;
                string t;
                e = exp_len.pop_front();
                t = exp_tag.pop_front();
                check((cyc - last_cyc) == e, t, cyc - last_cyc, e);
            end
            if (!scl_o) check(low_start === 1'b1, "R10 low_start at fall", int'(low_start), 1);
            else if (enable) check(high_start === 1'b1, "R10 high_start at rise", int'(high_start), 1);
            if (scl_o && enable && stretch_req > 0) begin
                hold = 1'b1;
                hold_left = stretch_req;
            end
            last_cyc = cyc;
            have_edge = 1;
        end
        if (!enable) have_edge = 0;
        prev_scl = scl_o;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        for (int w = 0; w < 150000 && !done; w++) @(posedge clk);
        if (!done) begin
            check(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        int still;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(scl_o === 1'b1, "R1 scl released in reset", int'(scl_o), 1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(scl_o === 1'b1, "R1 scl released idle", int'(scl_o), 1);
        check(low_start === 1'b0 && high_start === 1'b0, "R1 strobes idle",
              int'({low_start, high_start}), 0);

        // R3 R4 R5: lower bytes, prescaler 1
        run_case(1, 16'h0902, 16'h0803, 1'b0, 2, 0);
        // R2: larger prescaler scales every phase
        run_case(3, 16'h0001, 16'h0001, 1'b0, 2, 0);
        // R5: upper bytes selected
        run_case(1, 16'h0401, 16'h0902, 1'b1, 2, 0);
        // R7: stretched high phases
        run_case(1, 16'h0002, 16'h0003, 1'b0, 2, 5);

        // R6: select flipped during the first low phase
        psc_div = 8'd1; low_cfg = 16'h0402; high_cfg = 16'h0603; hs_sel = 1'b0;
        exp_len.push_back(18); exp_tag.push_back("R6 low keeps old byte");
        exp_len.push_back(22); exp_tag.push_back("R6 high uses new byte");
        exp_len.push_back(22); exp_tag.push_back("R6 next low uses new byte");
        enable = 1'b1;
        for (int g = 0; g < 100 && scl_o !== 1'b0; g++) @(negedge clk);
        repeat (2) @(negedge clk);
        hs_sel = 1'b1;
        wait_drain();
        enable = 1'b0;
        repeat (3) @(negedge clk);

        // R8: disable in the middle of a low phase, then a full restart
        hs_sel = 1'b0; low_cfg = 16'h0002; high_cfg = 16'h0003;
        enable = 1'b1;
        for (int g = 0; g < 100 && scl_o !== 1'b0; g++) @(negedge clk);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        check(scl_o === 1'b1, "R8 released after disable", int'(scl_o), 1);
        repeat (2) @(negedge clk);
        run_case(1, 16'h0002, 16'h0003, 1'b0, 1, 0);

        // R9: zero prescaler
        psc_div = 8'd0; low_cfg = 16'h0303; high_cfg = 16'h0303; hs_sel = 1'b0;
        @(negedge clk);
        check(cfg_bad === 1'b1, "R9 zero prescaler flagged", int'(cfg_bad), 1);
        enable = 1'b1;
        still = 0;
        for (int g = 0; g < 40; g++) begin
            @(negedge clk);
            if (scl_o !== 1'b1) still++;
        end
        check(still == 0, "R9 held released with bad divider", still, 0);
        enable = 1'b0;
        // R9: zero only in the selected upper byte
        psc_div = 8'd2; low_cfg = 16'h0003; hs_sel = 1'b1;
        @(negedge clk);
        check(cfg_bad === 1'b1, "R9 zero upper byte flagged", int'(cfg_bad), 1);
        hs_sel = 1'b0;
        @(negedge clk);
        check(cfg_bad === 1'b0, "R9 lower bytes valid", int'(cfg_bad), 0);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule